// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor and a slower line-oriented memory. It holds recently used lines in two ways per set. A word request from the processor is split into tag, set index and word offset. The index picks a set. The request tag is then matched against the tags of both ways of that set at the same time, with one comparator per way. A match in a valid way is a hit, and the offset picks the word inside the matching line.

On a miss the block chooses a victim way. An empty way is always taken before a filled one, and way 0 is taken before way 1. When both ways hold lines, a single bit per set names the way that was touched least recently. Reads and writes both count as touches. A dirty victim is first written back to memory as a whole line. The missing line is then read in, and the request completes as if it had hit. Writes that miss allocate the line first.

The processor side takes one request at a time with a ready/valid handshake. It gives one response pulse per request, and that pulse says whether the access hit. The memory side issues whole-line reads and writes and holds each one until the memory acknowledges it.

Top module: `cache2w_top`

## Requirements
- R1: A request hits when a valid way of the indexed set (index = word address bits just above the offset) holds the request tag. The response then has resp_hit=1 and, for a read, the stored word. An access that needed a fill responds with resp_hit=0 and the word fetched from memory.
- R2: A line is held by at most one way of a set. Two lines with different tags and the same index live side by side in the two ways and each returns its own data.
- R3: The low log2(LINE_WORDS) bits of the word address select the word in the line. A write changes only that word of the line.
- R4: On a miss in a set with an invalid way, the line goes to the lowest-numbered invalid way. No valid line is evicted.
- R5: On a miss in a set whose two ways are both valid, the way named by that set's LRU bit is evicted (LRU bit 0 names way 0, 1 names way 1).
- R6: Every access to way w, whether a read or a write, a hit or a filled miss, leaves the set's LRU bit naming the other way.
- R7: A write hit marks the way dirty. A write miss first fills the line and then writes it. Evicting a dirty way issues a line write (mem_we=1) of its contents before the fill read, so a later read of that word returns the written value.
- R8: Evicting a clean way issues no memory write.
- R9: Reset clears every valid bit, dirty bit and LRU bit. After reset req_ready=1, resp_valid=0 and mem_req=0, and the first access to any address misses.
- R10: req_ready is high only while no request is in progress. Each accepted request produces exactly one single-cycle resp_valid pulse, no earlier than the cycle after acceptance.
- R11: Once mem_req is raised, mem_we and mem_addr stay unchanged until the cycle of mem_ack. mem_addr is the line address {tag, index}, taken from the victim's tag for a write-back.
- R12: With one-word lines and two sets, the read sequence 0,2,0,1,4,0,2,3,5,4 from reset gives miss, miss, hit, miss, miss, hit, miss, miss, miss, miss, and address 4 replaces 2. The sequence 0,2,0,4,2 from reset gives miss, miss, hit, miss, miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write word |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | Request found its line without a fill |
| resp_rdata | output | DATA_W | Read word (zero for writes) |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = line write-back, 0 = line fill |
| mem_addr | output | ADDR_W-log2(LINE_WORDS) | Line address |
| mem_wdata | output | DATA_W*LINE_WORDS | Line being written back |
| mem_ack | input | 1 | Memory finished the transfer (one cycle) |
| mem_rdata | input | DATA_W*LINE_WORDS | Fill line, valid with mem_ack |

## Verification
The bench replays both worked access sequences. A victim choice that ignores the LRU bit, or one that skips an empty way, changes the hit/miss pattern at a known position. A separate run checks that writes touch the LRU. If only reads updated it, a line just written would be evicted, and that shows up as a miss and an extra write-back. Dirty and clean evictions are told apart by the memory write count and by the written-back address and word. A design that dropped dirty data or wrote back clean lines would fail there. A wider-line configuration checks that the offset picks the right word and that a partial write leaves the neighbouring words intact.

// File: rtl/cache2w_pkg.sv
`timescale 1ns/1ps
package cache2w_pkg;

   typedef enum logic [1:0] {
      CS_IDLE = 2'd0,
      CS_LOOK = 2'd1,
      CS_WB   = 2'd2,
      CS_FILL = 2'd3
   } cstate_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/cache_way.sv
`timescale 1ns/1ps
module cache_way #(
   parameter int SETS       = 16,
   parameter int TAG_W      = 10,
   parameter int DATA_W     = 32,
   parameter int LINE_WORDS = 4,
   parameter int OFFS_W     = 2,
   localparam int SET_W     = $clog2(SETS),
   localparam int LINE_W    = DATA_W * LINE_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SET_W-1:0]  rd_set,
   input  logic [TAG_W-1:0]  cmp_tag,
   output logic              hit,
   output logic              vld,
   output logic              dirty,
   output logic [TAG_W-1:0]  tag_o,
   output logic [LINE_W-1:0] line_o,
   input  logic              fill_en,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [LINE_W-1:0] fill_line,
   input  logic              wr_en,
   input  logic [OFFS_W-1:0] wr_off,
   input  logic [DATA_W-1:0] wr_word
);

   logic [SETS-1:0]   vld_q;
   logic [SETS-1:0]   dty_q;
   logic [TAG_W-1:0]  tag_q [SETS];
   logic [LINE_W-1:0] dat_q [SETS];

   assign vld    = vld_q[rd_set];
   assign dirty  = dty_q[rd_set];
   assign tag_o  = tag_q[rd_set];
   assign line_o = dat_q[rd_set];
   assign hit    = vld_q[rd_set] && (tag_q[rd_set] == cmp_tag);

   // state bits: cleared by reset
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         dty_q <= '0;
      end else if (fill_en) begin
         vld_q[rd_set] <= 1'b1;
         dty_q[rd_set] <= 1'b0;
      end else if (wr_en) begin
         dty_q[rd_set] <= 1'b1;
      end
   end

   // payload: no reset needed, guarded by valid
   always_ff @(posedge clk) begin
      if (fill_en) begin
         tag_q[rd_set] <= fill_tag;
         dat_q[rd_set] <= fill_line;
      end else if (wr_en) begin
         for (int k = 0; k < LINE_WORDS; k++) begin
            if (wr_off == OFFS_W'(k)) begin
               dat_q[rd_set][k*DATA_W +: DATA_W] <= wr_word;
            end
         end
      end
   end

endmodule

// File: rtl/cache_repl.sv
`timescale 1ns/1ps
module cache_repl #(
   parameter int SETS   = 16,
   localparam int SET_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] look_set,
   input  logic [1:0]       way_vld,
   output logic             victim,
   input  logic             touch_en,
   input  logic             touch_way,
   output logic [SETS-1:0]  lru_vec
);

   logic [SETS-1:0] lru_q;

   assign lru_vec = lru_q;

   // empty ways first, lowest number first, then the LRU way
   always_comb begin
      if (!way_vld[0])      victim = 1'b0;
      else if (!way_vld[1]) victim = 1'b1;
      else                  victim = lru_q[look_set];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lru_q <= '0;
      end else if (touch_en) begin
         lru_q[look_set] <= ~touch_way;
      end
   end

endmodule

// File: rtl/cache2w_top.sv
`timescale 1ns/1ps
module cache2w_top
   import cache2w_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 32,
   parameter int SETS       = 16,
   parameter int LINE_WORDS = 4,
   localparam int OFF_W     = $clog2(LINE_WORDS),
   localparam int SET_W     = $clog2(SETS),
   localparam int TAG_W     = ADDR_W - SET_W - OFF_W,
   localparam int LINE_AW   = TAG_W + SET_W,
   localparam int LINE_W    = DATA_W * LINE_WORDS,
   localparam int OFFS_W    = (OFF_W == 0) ? 1 : OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_wdata,
   output logic               resp_valid,
   output logic               resp_hit,
   output logic [DATA_W-1:0]  resp_rdata,
   output logic               mem_req,
   output logic               mem_we,
   output logic [LINE_AW-1:0] mem_addr,
   output logic [LINE_W-1:0]  mem_wdata,
   input  logic               mem_ack,
   input  logic [LINE_W-1:0]  mem_rdata
);

   // elaboration-time parameter checks
   if (!is_pow2(SETS) || SETS < 2) begin : g_bad_sets
      $error("cache2w_top: SETS must be a power of two >= 2");
   end
   if (!is_pow2(LINE_WORDS)) begin : g_bad_words
      $error("cache2w_top: LINE_WORDS must be a power of two");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("cache2w_top: ADDR_W too small for SETS and LINE_WORDS");
   end

   cstate_e           st_q;
   logic              wr_q;
   logic              miss_q;
   logic              vict_q;
   logic [TAG_W-1:0]  rtag_q;
   logic [SET_W-1:0]  rset_q;
   logic [OFFS_W-1:0] roff_q;
   logic [DATA_W-1:0] rwd_q;

   logic [OFFS_W-1:0] in_off;
   logic [1:0]        way_hit;
   logic [1:0]        way_vld;
   logic [1:0]        way_dty;
   logic [TAG_W-1:0]  way_tag  [2];
   logic [LINE_W-1:0] way_line [2];

   logic              in_look;
   logic              look_hit;
   logic              hit_way;
   logic              victim;
   logic              fill_go;
   logic [SETS-1:0]   lru_vec;
   logic [LINE_W-1:0] hit_line;
   logic [DATA_W-1:0] hit_word;

   // offset field exists only for multi-word lines
   if (OFF_W == 0) begin : g_off_none
      assign in_off = '0;
   end else begin : g_off_bits
      assign in_off = req_addr[OFF_W-1:0];
   end

   assign in_look  = (st_q == CS_LOOK);
   assign look_hit = in_look && (|way_hit);
   assign hit_way  = way_hit[1];
   assign fill_go  = (st_q == CS_FILL) && mem_ack;
   assign hit_line = way_line[hit_way];

   always_comb begin
      hit_word = '0;
      for (int k = 0; k < LINE_WORDS; k++) begin
         if (roff_q == OFFS_W'(k)) hit_word = hit_line[k*DATA_W +: DATA_W];
      end
   end

   for (genvar w = 0; w < 2; w++) begin : g_way
      cache_way #(
         .SETS       (SETS),
         .TAG_W      (TAG_W),
         .DATA_W     (DATA_W),
         .LINE_WORDS (LINE_WORDS),
         .OFFS_W     (OFFS_W)
      ) u_way (
         .clk       (clk),
         .rst_n     (rst_n),
         .rd_set    (rset_q),
         .cmp_tag   (rtag_q),
         .hit       (way_hit[w]),
         .vld       (way_vld[w]),
         .dirty     (way_dty[w]),
         .tag_o     (way_tag[w]),
         .line_o    (way_line[w]),
         .fill_en   (fill_go && (vict_q == 1'(w))),
         .fill_tag  (rtag_q),
         .fill_line (mem_rdata),
         .wr_en     (look_hit && wr_q && way_hit[w]),
         .wr_off    (roff_q),
         .wr_word   (rwd_q)
      );
   end

   cache_repl #(.SETS(SETS)) u_repl (
      .clk       (clk),
      .rst_n     (rst_n),
      .look_set  (rset_q),
      .way_vld   (way_vld),
      .victim    (victim),
      .touch_en  (look_hit),
      .touch_way (hit_way),
      .lru_vec   (lru_vec)
   );

   assign req_ready = (st_q == CS_IDLE);
   assign mem_req   = (st_q == CS_WB) || (st_q == CS_FILL);
   assign mem_we    = (st_q == CS_WB);
   assign mem_addr  = mem_we ? {way_tag[vict_q], rset_q} : {rtag_q, rset_q};
   assign mem_wdata = way_line[vict_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= CS_IDLE;
         resp_valid <= 1'b0;
         resp_hit   <= 1'b0;
         resp_rdata <= '0;
         miss_q     <= 1'b0;
         vict_q     <= 1'b0;
         wr_q       <= 1'b0;
         rtag_q     <= '0;
         rset_q     <= '0;
         roff_q     <= '0;
         rwd_q      <= '0;
      end else begin
         resp_valid <= 1'b0;
         unique case (st_q)
            CS_IDLE: begin
               if (req_valid) begin
                  wr_q   <= req_write;
                  rtag_q <= req_addr[ADDR_W-1 -: TAG_W];
                  rset_q <= req_addr[OFF_W +: SET_W];
                  roff_q <= in_off;
                  rwd_q  <= req_wdata;
                  miss_q <= 1'b0;
                  st_q   <= CS_LOOK;
               end
            end
            CS_LOOK: begin
               if (|way_hit) begin
                  resp_valid <= 1'b1;
                  resp_hit   <= !miss_q;
                  resp_rdata <= wr_q ? '0 : hit_word;
                  st_q       <= CS_IDLE;
               end else begin
                  miss_q <= 1'b1;
                  vict_q <= victim;
                  st_q   <= (way_vld[victim] && way_dty[victim]) ? CS_WB : CS_FILL;
               end
            end
            CS_WB: begin
               if (mem_ack) st_q <= CS_FILL;
            end
            CS_FILL: begin
               if (mem_ack) st_q <= CS_LOOK;
            end
            default: st_q <= CS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cache2w_chk.sv
`timescale 1ns/1ps
module cache2w_chk #(
   parameter int SETS    = 16,
   parameter int LINE_AW = 12,
   localparam int SET_W  = $clog2(SETS)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_look,
   input logic [1:0]         way_hit,
   input logic               resp_valid,
   input logic               req_ready,
   input logic               mem_req,
   input logic               mem_we,
   input logic               mem_ack,
   input logic [LINE_AW-1:0] mem_addr,
   input logic               look_hit,
   input logic               hit_way,
   input logic [SET_W-1:0]   rset_q,
   input logic [SETS-1:0]    lru_vec
);

   // R2: the two way comparators never both match
   p_one_way_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_look |-> $onehot0(way_hit));

   // R10: response is a single-cycle pulse
   p_resp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);

   // R10: a response finds the block idle again
   p_resp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> req_ready);

   // R10: no new request is taken while a memory transfer runs
   p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !req_ready);

   // R11: memory request held with stable address and direction
   p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R7: a finished write-back is followed by the fill read
   p_wb_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

   // R6: the touched way is no longer the LRU choice
   p_lru_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
      look_hit |=> (lru_vec[$past(rset_q)] != $past(hit_way)));

endmodule

bind cache2w_top cache2w_chk #(.SETS(SETS), .LINE_AW(LINE_AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_look    (in_look),
   .way_hit    (way_hit),
   .resp_valid (resp_valid),
   .req_ready  (req_ready),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_ack    (mem_ack),
   .mem_addr   (mem_addr),
   .look_hit   (look_hit),
   .hit_way    (hit_way),
   .rset_q     (rset_q),
   .lru_vec    (lru_vec)
);

// File: tb/sim_cache2w_top.sv
`timescale 1ns/1ps
module sim_mem #(
   parameter int AW = 8,
   parameter int LW = 1,
   parameter int DW = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             we,
   input  logic [AW-1:0]    addr,
   input  logic [LW*DW-1:0] wdata,
   output logic             ack,
   output logic [LW*DW-1:0] rdata,
   output int               wr_cnt,
   output logic [AW-1:0]    last_waddr,
   output logic [LW*DW-1:0] last_wdata
);
   logic [LW*DW-1:0] mem [1<<AW];
   int cnt;

   initial begin
      for (int l = 0; l < (1 << AW); l++)
         for (int k = 0; k < LW; k++)
            mem[l][k*DW +: DW] = 32'h5A00_0000 | (l * LW + k);
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         ack <= 1'b0; cnt <= 0; wr_cnt <= 0;
         last_waddr <= '0; last_wdata <= '0; rdata <= '0;
      end else if (req && !ack) begin
         if (cnt == 2) begin
            ack <= 1'b1; cnt <= 0;
            if (we) begin
               mem[addr] <= wdata; wr_cnt <= wr_cnt + 1;
               last_waddr <= addr; last_wdata <= wdata;
            end else begin
               rdata <= mem[addr];
            end
         end else begin
            cnt <= cnt + 1;
         end
      end else begin
         ack <= 1'b0;
      end
   end
endmodule

module sim_cache2w_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   typedef struct {
      bit          hit;
      bit          chk;
      logic [31:0] data;
      string       rq;
   } exp_t;
   exp_t q0[$];
   exp_t q1[$];
   logic [31:0] sh0 [256];
   logic [31:0] sh1 [256];

   // instance 0: one-word lines, two sets
   logic v0 = 0, w0 = 0;
   logic [7:0] a0 = 0;
   logic [31:0] d0 = 0;
   logic rdy0, rv0, rh0, mreq0, mwe0, mack0;
   logic [31:0] rd0, mwd0, mrd0, lwd0;
   logic [7:0] maddr0, lwa0;
   int wc0;

   // instance 1: four-word lines, four sets
   logic v1 = 0, w1 = 0;
   logic [7:0] a1 = 0;
   logic [31:0] d1 = 0;
   logic rdy1, rv1, rh1, mreq1, mwe1, mack1;
   logic [31:0] rd1;
   logic [127:0] mwd1, mrd1, lwd1;
   logic [5:0] maddr1, lwa1;
   int wc1;

   cache2w_top #(.ADDR_W(8), .DATA_W(32), .SETS(2), .LINE_WORDS(1)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(v0), .req_ready(rdy0), .req_write(w0),
      .req_addr(a0), .req_wdata(d0), .resp_valid(rv0), .resp_hit(rh0), .resp_rdata(rd0),
      .mem_req(mreq0), .mem_we(mwe0), .mem_addr(maddr0), .mem_wdata(mwd0),
      .mem_ack(mack0), .mem_rdata(mrd0));
   sim_mem #(.AW(8), .LW(1), .DW(32)) m0 (
      .clk(clk), .rst_n(rst_n), .req(mreq0), .we(mwe0), .addr(maddr0), .wdata(mwd0),
      .ack(mack0), .rdata(mrd0), .wr_cnt(wc0), .last_waddr(lwa0), .last_wdata(lwd0));

   cache2w_top #(.ADDR_W(8), .DATA_W(32), .SETS(4), .LINE_WORDS(4)) u1 (
      .clk(clk), .rst_n(rst_n), .req_valid(v1), .req_ready(rdy1), .req_write(w1),
      .req_addr(a1), .req_wdata(d1), .resp_valid(rv1), .resp_hit(rh1), .resp_rdata(rd1),
      .mem_req(mreq1), .mem_we(mwe1), .mem_addr(maddr1), .mem_wdata(mwd1),
      .mem_ack(mack1), .mem_rdata(mrd1));
   sim_mem #(.AW(6), .LW(4), .DW(32)) m1 (
      .clk(clk), .rst_n(rst_n), .req(mreq1), .we(mwe1), .addr(maddr1), .wdata(mwd1),
      .ack(mack1), .rdata(mrd1), .wr_cnt(wc1), .last_waddr(lwa1), .last_wdata(lwd1));

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   // driver: pushes the expected response, then issues the request
   task automatic issue(input int u, input bit we, input logic [7:0] a,
                        input logic [31:0] wd, input bit eh, input string rq);
      exp_t e;
      e.hit = eh; e.chk = !we; e.rq = rq;
      if (u == 0) begin
         if (we) sh0[a] = wd;
         e.data = sh0[a]; q0.push_back(e);
         v0 = 1; w0 = we; a0 = a; d0 = wd;
      end else begin
         if (we) sh1[a] = wd;
         e.data = sh1[a]; q1.push_back(e);
         v1 = 1; w1 = we; a1 = a; d1 = wd;
      end
      @(negedge clk);
      v0 = 0; v1 = 0;
      while (!(u == 0 ? rdy0 : rdy1)) @(negedge clk);
   endtask

   // monitor: pops expected items as responses appear
   always @(negedge clk) begin
      if (rst_n && rv0) begin
         if (q0.size() == 0) check(0, "R10", "u0 extra response", 1, 0);
         else begin
            exp_t e;
            e = q0.pop_front();
            check(rh0 == e.hit, e.rq, "u0 hit flag", rh0, e.hit);
            if (e.chk) check(rd0 == e.data, e.rq, "u0 read data", rd0, e.data);
         end
      end
      if (rst_n && rv1) begin
         if (q1.size() == 0) check(0, "R10", "u1 extra response", 1, 0);
         else begin
            exp_t e;
            e = q1.pop_front();
            check(rh1 == e.hit, e.rq, "u1 hit flag", rh1, e.hit);
            if (e.chk) check(rd1 == e.data, e.rq, "u1 read data", rd1, e.data);
         end
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R9: idle state after reset
      check(rdy0 && rdy1, "R9", "req_ready after reset", {rdy1, rdy0}, 2'b11);
      check(!rv0 && !rv1, "R9", "resp_valid after reset", {rv1, rv0}, 0);
      check(!mreq0 && !mreq1, "R9", "mem_req after reset", {mreq1, mreq0}, 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         total++; bad++;
         $display("FAIL watchdog R10: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int wsnap;
      for (int i = 0; i < 256; i++) begin
         sh0[i] = 32'h5A00_0000 | i;
         sh1[i] = 32'h5A00_0000 | i;
      end
      do_reset();

      // R12 sequence A (R4 empty-way fill, R5 LRU eviction)
      issue(0, 0, 0, 0, 0, "R12/R9");
      issue(0, 0, 2, 0, 0, "R12/R4");
      issue(0, 0, 0, 0, 1, "R12/R1");
      issue(0, 0, 1, 0, 0, "R12/R4");
      issue(0, 0, 4, 0, 0, "R12/R5");
      issue(0, 0, 0, 0, 1, "R12/R5");
      issue(0, 0, 2, 0, 0, "R12/R5");
      issue(0, 0, 3, 0, 0, "R12/R4");
      issue(0, 0, 5, 0, 0, "R12/R5");
      issue(0, 0, 4, 0, 0, "R12/R5");

      // R12 sequence B from reset
      do_reset();
      issue(0, 0, 0, 0, 0, "R12/R9");
      issue(0, 0, 2, 0, 0, "R12");
      issue(0, 0, 0, 0, 1, "R12");
      issue(0, 0, 4, 0, 0, "R12");
      issue(0, 0, 2, 0, 0, "R12");

      // R6 writes touch LRU, R7 dirty write-back, R8 clean eviction
      do_reset();
      issue(0, 0, 0, 0, 0, "R6");
      issue(0, 0, 2, 0, 0, "R6");
      issue(0, 1, 0, 32'h1111_0000, 1, "R6/R7");
      wsnap = wc0;
      issue(0, 0, 4, 0, 0, "R6/R8");
      check(wc0 == wsnap, "R8", "clean victim write count", wc0, wsnap);
      issue(0, 0, 0, 0, 1, "R6");
      issue(0, 0, 4, 0, 1, "R6");
      issue(0, 0, 6, 0, 0, "R7");
      check(wc0 == wsnap + 1, "R7", "dirty victim write count", wc0, wsnap + 1);
      check(lwa0 == 8'h00, "R11", "write-back line address", lwa0, 0);
      check(lwd0 == 32'h1111_0000, "R7", "write-back data", lwd0, 32'h1111_0000);
      issue(0, 0, 0, 0, 0, "R7");
      issue(0, 1, 8, 32'h8888_0008, 0, "R7");
      issue(0, 0, 8, 0, 1, "R7/R1");

      // R3 word select with four-word lines, R2 two tags in one set
      issue(1, 0, 8'h11, 0, 0, "R3");
      issue(1, 0, 8'h12, 0, 1, "R3");
      issue(1, 0, 8'h13, 0, 1, "R3");
      issue(1, 0, 8'h10, 0, 1, "R3");
      issue(1, 1, 8'h12, 32'h2222_0001, 1, "R3/R7");
      issue(1, 0, 8'h12, 0, 1, "R3");
      issue(1, 0, 8'h11, 0, 1, "R3");
      issue(1, 0, 8'h51, 0, 0, "R2");
      issue(1, 0, 8'h11, 0, 1, "R2");
      issue(1, 0, 8'h53, 0, 1, "R2");
      wsnap = wc1;
      issue(1, 0, 8'h91, 0, 0, "R5/R7");
      check(wc1 == wsnap + 1, "R7", "u1 dirty write count", wc1, wsnap + 1);
      check(lwa1 == 6'h04, "R11", "u1 write-back line address", lwa1, 6'h04);
      check(lwd1[64 +: 32] == 32'h2222_0001, "R3", "u1 written word in line",
            lwd1[64 +: 32], 32'h2222_0001);
      check(lwd1[32 +: 32] == 32'h5A00_0011, "R3", "u1 neighbour word in line",
            lwd1[32 +: 32], 32'h5A00_0011);

      repeat (5) @(negedge clk);
      check(q0.size() == 0 && q1.size() == 0, "R10", "missing responses",
            q0.size() + q1.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule